// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This block sequences whole-array transfers between a working SRAM image and its nonvolatile shadow. A STORE copies the SRAM into the shadow, and a RECALL copies it back. The copy is modelled as a fixed number of busy cycles. After reset the block always runs a RECALL. Three sources can ask for a STORE:

- a software strobe, which always runs;
- an active-low hardware request pin;
- a power-fail input.

The hardware request and the power-fail event only run when a write latch shows that the SRAM has changed since the last transfer.

The hardware request pin and the power-fail input are asynchronous and pass through synchronizers first. A falling hardware request opens a grace window. SRAM writes already under way may complete during this window and still count as changes. While a transfer runs, the block pulls its open-drain style busy output. SRAM accesses are blocked whenever a transfer, a grace window or a hold is in progress, and also while the hardware request pin stays low.

A saturating counter tracks completed stores. Its wear flag rises once the endurance limit is reached.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset is released the block runs a RECALL. `busy_pull` and `access_block` are high for exactly RECALL_CYCLES cycles, and then both fall. `wr_latch` and `store_count` start at zero.
- R2: A one-cycle `sw_store` strobe received while idle starts a STORE on the next edge, whatever the value of `wr_latch`. `busy_pull` stays high for exactly STORE_CYCLES cycles.
- R3: A falling edge on `hw_req_n` is first seen after SYNC_STAGES synchronizer cycles. One edge-detect cycle follows, then a grace window of GRACE_CYCLES cycles. A STORE starts after that only if `wr_latch` is set.
- R4: If `wr_latch` is clear when the grace window ends, no STORE runs and `busy_pull` stays low. `access_block` remains high until `hw_req_n` returns high. `access_block` is also high whenever `hw_req_n` is low after synchronization.
- R5: A rising edge on `pwr_fail` starts a STORE only if auto-store is enabled and `wr_latch` is set. Otherwise it has no effect, and `wr_latch` keeps its value.
- R6: Auto-store (`auto_en`) is enabled after reset. A `sw_auto_off` strobe disables it and a `sw_auto_on` strobe re-enables it; off wins if both are present.
- R7: A `wr_done` pulse sets `wr_latch` while the block is idle or in a grace window. The pulse is ignored during a STORE, a RECALL or a hold. The last cycle of every STORE or RECALL clears the latch.
- R8: `store_count` increases by one at the end of each STORE and saturates at its all-ones value. `wear_out` is high once the count reaches WEAR_LIMIT and stays high.
- R9: `busy_pull` is high only during a STORE or a RECALL. A STORE request that arrives while the block is not idle is dropped.
- R10: A `wr_done` pulse that arrives during the grace window counts. A hardware request made with a clear latch then still produces a STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req_n | input | 1 | Asynchronous hardware store request, active low |
| pwr_fail | input | 1 | Asynchronous power-fail indication; its rising edge requests auto-store |
| sw_store | input | 1 | Software store strobe, one cycle |
| sw_auto_off | input | 1 | Software strobe that disables auto-store |
| sw_auto_on | input | 1 | Software strobe that enables auto-store |
| wr_done | input | 1 | Pulse marking a completed SRAM write |
| busy_pull | output | 1 | High while a transfer runs; drives the open-drain busy line low |
| access_block | output | 1 | SRAM read and write accesses must be held off |
| wr_latch | output | 1 | SRAM modified since the last transfer |
| auto_en | output | 1 | Auto-store enabled |
| store_count | output | CNT_W | Saturating count of completed stores |
| wear_out | output | 1 | Endurance limit reached |

## Verification
The bench targets the following corner cases, together with the failure each one would expose:

- **Conditional requests with a clean image.** A hardware or power-fail request arrives while the image is clean. A design that ignored the latch would start a pointless STORE and increase the counter.
- **Leftover latch.** The latch is left set by a power-fail request that was refused because auto-store was off. A later hardware request must then store. A design that wrongly cleared the latch would skip that STORE.
- **Write inside the grace window.** A write completes during the grace window. A design that sampled the latch too early would hold instead of storing.
- **Inputs during a STORE.** A write and a second software request both arrive during a STORE. A design that accepted either would leave the latch set after the STORE, or would stretch the busy period.
- **Exact timing.** The bench counts the exact cycle on which busy starts and the exact busy length. A grace window or recall that is off by one cycle would show in these counts.
- **Counter limits.** The counter is driven past the wear limit and on into saturation. A wrap-around or a non-sticky wear flag would be detected.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

   typedef enum logic [2:0] {
      ST_RECALL = 3'd0,
      ST_IDLE   = 3'd1,
      ST_GRACE  = 3'd2,
      ST_HOLD   = 3'd3,
      ST_STORE  = 3'd4
   } nvx_state_e;

   function automatic int nvx_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nvx_sync.sv
module nvx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise
);

   logic prev;

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[STAGES-2+((STAGES>1)?0:1):0], d} ;
         end
         assign lvl = sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;

endmodule

// File: rtl/nvx_timer.sv
module nvx_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= W'(RST_VAL);
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/nvx_wear.sv
module nvx_wear #(
   parameter int          W     = 18,
   parameter int unsigned LIMIT = 200000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count,
   output logic         worn
);

   localparam logic [W-1:0] CMAX = {W{1'b1}};
   localparam logic [W-1:0] CLIM = W'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (inc && count != CMAX) count <= count + 1'b1;
   end

   assign worn = (count >= CLIM);

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
   import nvx_pkg::*;
#(
   parameter int          STORE_CYCLES  = 64,
   parameter int          RECALL_CYCLES = 32,
   parameter int          GRACE_CYCLES  = 16,
   parameter int          SYNC_STAGES   = 2,
   parameter int          CNT_W         = 18,
   parameter int unsigned WEAR_LIMIT    = 200000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_req_n,
   input  logic             pwr_fail,
   input  logic             sw_store,
   input  logic             sw_auto_off,
   input  logic             sw_auto_on,
   input  logic             wr_done,
   output logic             busy_pull,
   output logic             access_block,
   output logic             wr_latch,
   output logic             auto_en,
   output logic [CNT_W-1:0] store_count,
   output logic             wear_out
);

   localparam int MAXC = nvx_max3(STORE_CYCLES, RECALL_CYCLES, GRACE_CYCLES);
   localparam int TW   = $clog2(MAXC + 1);

   generate
      if (STORE_CYCLES < 1 || RECALL_CYCLES < 1 || GRACE_CYCLES < 1) begin : g_bad_len
         $error("nv_xfer_ctrl: transfer and grace lengths must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("nv_xfer_ctrl: SYNC_STAGES must not be negative");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_w
         $error("nv_xfer_ctrl: CNT_W out of range");
      end
      if (WEAR_LIMIT > ((32'd1 << CNT_W) - 1)) begin : g_bad_lim
         $error("nv_xfer_ctrl: WEAR_LIMIT does not fit the counter");
      end
   endgenerate

   nvx_state_e    st, st_n;
   logic          hw_low, hw_rise, pf_lvl, pf_rise;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic          store_end, recall_end;

   nvx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_hw (
      .clk(clk), .rst_n(rst_n), .d(~hw_req_n), .lvl(hw_low), .rise(hw_rise));

   nvx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_pf (
      .clk(clk), .rst_n(rst_n), .d(pwr_fail), .lvl(pf_lvl), .rise(pf_rise));

   nvx_timer #(.W(TW), .RST_VAL(RECALL_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

   nvx_wear #(.W(CNT_W), .LIMIT(WEAR_LIMIT)) i_wear (
      .clk(clk), .rst_n(rst_n), .inc(store_end), .count(store_count), .worn(wear_out));

   always_comb begin
      st_n       = st;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      store_end  = 1'b0;
      recall_end = 1'b0;
      unique case (st)
         ST_RECALL: begin
            if (tmr_zero) begin
               st_n       = ST_IDLE;
               recall_end = 1'b1;
            end
         end
         ST_IDLE: begin
            if ((pf_rise && auto_en && wr_latch) || sw_store) begin
               st_n     = ST_STORE;
               tmr_load = 1'b1;
               tmr_val  = TW'(STORE_CYCLES - 1);
            end else if (hw_rise) begin
               st_n     = ST_GRACE;
               tmr_load = 1'b1;
               tmr_val  = TW'(GRACE_CYCLES - 1);
            end
         end
         ST_GRACE: begin
            if (tmr_zero) begin
               if (wr_latch) begin
                  st_n     = ST_STORE;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(STORE_CYCLES - 1);
               end else begin
                  st_n = ST_HOLD;
               end
            end
         end
         ST_HOLD: begin
            if (!hw_low) st_n = ST_IDLE;
         end
         ST_STORE: begin
            if (tmr_zero) begin
               st_n      = ST_IDLE;
               store_end = 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RECALL;
      else        st <= st_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         wr_latch <= 1'b0;
      else if (store_end || recall_end)                   wr_latch <= 1'b0;
      else if (wr_done && (st == ST_IDLE || st == ST_GRACE)) wr_latch <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           auto_en <= 1'b1;
      else if (sw_auto_off) auto_en <= 1'b0;
      else if (sw_auto_on)  auto_en <= 1'b1;
   end

   assign busy_pull    = (st == ST_STORE) || (st == ST_RECALL);
   assign access_block = (st != ST_IDLE) || hw_low;

   logic unused_pf;
   assign unused_pf = pf_lvl;

endmodule

// File: rtl/nv_xfer_ctrl_chk.sv
module nv_xfer_ctrl_chk #(
   parameter int CNT_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_pull,
   input logic             access_block,
   input logic             wr_latch,
   input logic [CNT_W-1:0] store_count,
   input logic             wear_out
);

   // R9: a transfer in progress always holds off SRAM access
   p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_pull |-> access_block);

   // R7: the latch is clear when a transfer finishes
   p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_pull) |-> !wr_latch);

   // R8: the counter only ever steps by one
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (store_count != $past(store_count)) |-> (store_count == CNT_W'($past(store_count) + 1'b1)));

   // R2: the counter moves only as a busy period ends
   p_count_on_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (store_count != $past(store_count)) |-> ($past(busy_pull) && !busy_pull));

   // R8: saturation holds
   p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&store_count) |=> (&store_count));

   // R8: wear flag is sticky
   p_wear_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wear_out |=> wear_out);

endmodule

bind nv_xfer_ctrl nv_xfer_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .busy_pull(busy_pull), .access_block(access_block),
   .wr_latch(wr_latch), .store_count(store_count), .wear_out(wear_out));

// File: tb/test_nv_xfer_ctrl.sv
`timescale 1ns/1ps
module test_nv_xfer_ctrl;

   localparam int S = 8, R = 6, G = 4, SY = 2, CW = 3, LIM = 5, CMAX = 7;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, hw_req_n, pwr_fail, sw_store, sw_auto_off, sw_auto_on, wr_done;
   logic busy_pull, access_block, wr_latch, auto_en, wear_out;
   logic [CW-1:0] store_count;

   nv_xfer_ctrl #(.STORE_CYCLES(S), .RECALL_CYCLES(R), .GRACE_CYCLES(G),
                  .SYNC_STAGES(SY), .CNT_W(CW), .WEAR_LIMIT(LIM)) i_nv_xfer_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_req_n(hw_req_n), .pwr_fail(pwr_fail),
      .sw_store(sw_store), .sw_auto_off(sw_auto_off), .sw_auto_on(sw_auto_on),
      .wr_done(wr_done), .busy_pull(busy_pull), .access_block(access_block),
      .wr_latch(wr_latch), .auto_en(auto_en), .store_count(store_count),
      .wear_out(wear_out));

   int checks = 0, errors = 0;
   int cnt_m = 0, latch_m = 0;
   bit finished = 0;

   // {op[1:0], wr, auto_off, expect_store}; op 0 software, 1 hardware pin, 2 power-fail
   localparam logic [4:0] VEC [9] = '{
      5'b00_0_0_1, 5'b00_1_0_1, 5'b01_0_0_0, 5'b01_1_0_1, 5'b10_1_0_1,
      5'b10_0_0_0, 5'b10_1_1_0, 5'b01_0_0_1, 5'b00_0_0_1 };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_op(input int op, input bit wr, input bit aoff, input int inj_wr,
                         input int inj_sw, output int first, output int len, output int blk);
      if (wr) begin wr_done = 1'b1; tick(1); wr_done = 1'b0; tick(1); end
      if (aoff) begin
         sw_auto_off = 1'b1; tick(1); sw_auto_off = 1'b0; tick(1);
         chk("R6", "auto_en after off", auto_en, 0);
      end
      case (op)
         0: sw_store = 1'b1;
         1: hw_req_n = 1'b0;
         default: pwr_fail = 1'b1;
      endcase
      first = 0; len = 0; blk = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (busy_pull) begin len++; if (first == 0) first = i; end
         if (i == 30) blk = access_block;
         if (i == 1) sw_store = 1'b0;
         if (i == inj_wr) wr_done = 1'b1;
         if (i == inj_wr + 1) wr_done = 1'b0;
         if (i == inj_sw) sw_store = 1'b1;
         if (i == inj_sw + 1) sw_store = 1'b0;
      end
      hw_req_n = 1'b1; pwr_fail = 1'b0;
      tick(6);
      if (aoff) begin sw_auto_on = 1'b1; tick(1); sw_auto_on = 1'b0; tick(1); end
   endtask

   function automatic int exp_first(input int op);
      if (op == 0) return 1;
      if (op == 1) return SY + 1 + G;
      return SY + 1;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int first, len, blk, nb;
      rst_n = 1'b0; hw_req_n = 1'b1; pwr_fail = 1'b0; sw_store = 1'b0;
      sw_auto_off = 1'b0; sw_auto_on = 1'b0; wr_done = 1'b0;
      tick(3);
      // R1 reset state
      chk("R1", "busy in reset", busy_pull, 1);
      chk("R1", "block in reset", access_block, 1);
      chk("R1", "latch in reset", wr_latch, 0);
      chk("R8", "count in reset", store_count, 0);
      chk("R6", "auto_en default", auto_en, 1);
      rst_n = 1'b1;
      nb = 0;
      for (int i = 1; i <= 20; i++) begin @(negedge clk); if (busy_pull) nb++; end
      chk("R1", "recall length", nb, R);
      chk("R1", "block after recall", access_block, 0);

      // table of stimulus and expected outcome
      for (int v = 0; v < 9; v++) begin
         int op; bit wr, aoff, ex;
         op = int'(VEC[v][4:3]); wr = VEC[v][2]; aoff = VEC[v][1]; ex = VEC[v][0];
         run_op(op, wr, aoff, 0, 0, first, len, blk);
         if (wr) latch_m = 1;
         if (ex) begin latch_m = 0; if (cnt_m < CMAX) cnt_m++; end
         chk(op == 0 ? "R2" : (op == 1 ? "R3" : "R5"), $sformatf("vec %0d busy len", v), len, ex ? S : 0);
         chk(op == 0 ? "R2" : (op == 1 ? "R3" : "R5"), $sformatf("vec %0d start", v), first, ex ? exp_first(op) : 0);
         chk("R7", $sformatf("vec %0d latch", v), wr_latch, latch_m);
         chk("R8", $sformatf("vec %0d count", v), store_count, cnt_m);
         chk("R8", $sformatf("vec %0d wear", v), wear_out, (cnt_m >= LIM) ? 1 : 0);
         if (op == 1) begin
            chk("R4", $sformatf("vec %0d block while pin low", v), blk, 1);
            chk("R4", $sformatf("vec %0d block after release", v), access_block, 0);
         end
         chk("R6", $sformatf("vec %0d auto_en", v), auto_en, 1);
      end

      // R9 / R7: write and second software request during a STORE are dropped
      run_op(0, 0, 0, 3, 4, first, len, blk);
      chk("R9", "second request ignored", len, S);
      chk("R7", "write during store ignored", wr_latch, 0);
      chk("R8", "count after one store", store_count, 7);

      // R10: write completing in the grace window
      run_op(1, 0, 0, 3, 0, first, len, blk);
      chk("R10", "grace write start", first, SY + 1 + G);
      chk("R10", "grace write busy len", len, S);
      chk("R7", "latch clear after grace store", wr_latch, 0);
      chk("R8", "count saturated", store_count, CMAX);

      run_op(0, 0, 0, 0, 0, first, len, blk);
      chk("R8", "count stays saturated", store_count, CMAX);
      chk("R8", "wear stays high", wear_out, 1);

      // R6: off then on restores auto-store
      sw_auto_off = 1'b1; tick(1); sw_auto_off = 1'b0;
      sw_auto_on = 1'b1; tick(1); sw_auto_on = 1'b0; tick(1);
      chk("R6", "auto_en re-enabled", auto_en, 1);
      run_op(2, 1, 0, 0, 0, first, len, blk);
      chk("R6", "power-fail store after re-enable", len, S);
      chk("R5", "power-fail start", first, SY + 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule